// File: doc/BRIEF.md
# Windowed Watchdog with Refresh Signature Check

This block supervises software through a two-phase watchdog sequence. After a start pulse it opens a closed first window. Any refresh or stop request during that window is treated as abuse. An open second window follows, in which software must refresh or stop the watchdog. If the second window runs out, a timeout interrupt is raised. A system-error pulse then follows, either at once or after a programmable escalation delay, which gives software time to record state before the error is reported.

A legal refresh restarts the whole sequence. When the signature check is enabled, a refresh is accepted only if the two task-signature inputs hold the same value. A mismatch is reported as a violation. A 2-bit selector places the window interrupt at the start of the second window or at a quarter, half or three quarters of the way through it. Two sticky flags record violations and system errors until software clears them.

Cycle numbering used below: cycle 0 is the rising edge that samples `start_i` (or the edge that samples an accepted refresh). Cycle n is the n-th rising edge after it. A request belongs to the cycle of the edge that samples it. Output pulses are registered, last one clock, and are visible right after the edge of their cycle. F, S and T are `first_len_i`, `second_len_i` and `delay_len_i`.

Top module: `wdt_windowed`

## Requirements
- R1: After reset all three pulse outputs and both flags are 0 and the watchdog is idle; an asynchronous reset applied during any window or delay produces no pulse afterwards.
- R2: A `start_i` pulse while idle begins a sequence: cycles 1..F form the first window and cycles F+1..F+S form the second window; with F = 0 the sequence begins directly in the second window.
- R3: A refresh or stop request in the first window (cycles 1..F) produces a `sys_err_o` pulse in that same cycle, sets `viol_flag_o`, and halts the watchdog.
- R4: `win_irq_o` pulses in cycle F+1+floor(S*k/4), where k = `irq_sel_i` (0 to 3), unless a request is sampled in that cycle.
- R5: With no action in the second window, `tmo_irq_o` pulses in cycle F+S; if `delay_en_i` = 0, `sys_err_o` pulses in the same cycle and the watchdog halts.
- R6: With `delay_en_i` = 1, `sys_err_o` pulses in cycle F+S+T and the watchdog then halts; refresh and stop requests sampled during the delay are ignored.
- R7: A refresh accepted in the second window restarts the sequence, with the refresh cycle serving as the new cycle 0.
- R8: A stop request in the second window halts the watchdog with no pulse and no flag change.
- R9: With `sig_en_i` = 1, a refresh in the second window with `sig_a_i` != `sig_b_i` produces a `sys_err_o` pulse in that cycle, sets `viol_flag_o`, and halts; with `sig_en_i` = 0 the signatures are not compared.
- R10: A refresh sampled in the last second-window cycle (F+S) wins over the expiry, so no timeout occurs; a refresh and a stop in the same second-window cycle act as a refresh.
- R11: `viol_flag_o` and `sys_flag_o` (set by every `sys_err_o` pulse) hold until a cycle with `flag_clr_i[0]` or `flag_clr_i[1]` respectively; a set in the same cycle as its clear wins.
- R12: `start_i` is ignored while a sequence or delay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a watchdog sequence when idle |
| refresh_i | input | 1 | Refresh (service) request |
| stop_i | input | 1 | Stop or reconfigure request |
| first_len_i | input | CW | First (closed) window length in cycles |
| second_len_i | input | CW | Second (open) window length in cycles |
| delay_len_i | input | CW | Escalation delay length in cycles |
| delay_en_i | input | 1 | Enable the escalation delay |
| sig_en_i | input | 1 | Enable the signature comparison on refresh |
| irq_sel_i | input | 2 | Window interrupt placement: 0 start, 1 quarter, 2 half, 3 three quarters |
| sig_a_i | input | SW | Reference task signature |
| sig_b_i | input | SW | Signature presented with the refresh |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 violation flag, bit 1 system-error flag |
| win_irq_o | output | 1 | Window interrupt pulse |
| tmo_irq_o | output | 1 | Timeout interrupt pulse |
| sys_err_o | output | 1 | System-error pulse |
| viol_flag_o | output | 1 | Sticky violation flag |
| sys_flag_o | output | 1 | Sticky system-error flag |

## Verification
The expiry of the second window and a refresh can fall in the same cycle. The bench provokes this by sampling a refresh exactly in cycle F+S. It then requires that no timeout appears and that a fresh window interrupt and timeout follow from the new cycle 0. A second collision, a violation sampled in the same cycle as a clear of the flags, is judged by requiring the flags to read 1 afterwards. Every pulse is matched against a queue of expected kinds and cycle numbers, so an early, late, missing or extra pulse is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DELAY  = 2'd3
  } wdt_state_e;

  localparam int NFLAG    = 2;
  localparam int FLAG_VIO = 0;
  localparam int FLAG_SYS = 1;
endpackage

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  // a length of 0 behaves like a length of 1
  assign last = (cnt <= CW'(1));
endmodule

// File: rtl/wdt_irq_point.sv
module wdt_irq_point #(
  parameter int CW = 16
) (
  input  logic [1:0]    sel,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] tgt
);
  localparam int PW = CW + 2;
  logic [PW-1:0] triple;
  logic [PW-1:0] thr;

  always_comb begin
    triple = {1'b0, len, 1'b0} + {2'b00, len};
    case (sel)
      2'd1:    thr = {2'b00, len} >> 2;
      2'd2:    thr = {2'b00, len} >> 1;
      2'd3:    thr = triple >> 2;
      default: thr = '0;
    endcase
    // counter value seen at the edge where the interrupt is due
    tgt = len - thr[CW-1:0];
  end
endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set | clr;
    q_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (q_en) begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          refresh_i,
  input  logic          stop_i,
  input  logic [CW-1:0] first_len_i,
  input  logic [CW-1:0] second_len_i,
  input  logic [CW-1:0] delay_len_i,
  input  logic          delay_en_i,
  input  logic          sig_en_i,
  input  logic [1:0]    irq_sel_i,
  input  logic [SW-1:0] sig_a_i,
  input  logic [SW-1:0] sig_b_i,
  input  logic [1:0]    flag_clr_i,
  output logic          win_irq_o,
  output logic          tmo_irq_o,
  output logic          sys_err_o,
  output logic          viol_flag_o,
  output logic          sys_flag_o
);
  wdt_state_e    state_q, state_d;
  logic          ld, dec, last;
  logic [CW-1:0] ld_val, cnt, win_tgt;
  logic          any_req, sig_bad, win_hit;
  logic          skip_first;
  logic          win_d, tmo_d, sys_d, viol_d;
  logic          win_q, tmo_q, sys_q;
  logic [NFLAG-1:0] flag_set, flag_q;

  wdt_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .dec      (dec),
    .cnt      (cnt),
    .last     (last)
  );

  wdt_irq_point #(.CW(CW)) u_irq_point (
    .sel (irq_sel_i),
    .len (second_len_i),
    .tgt (win_tgt)
  );

  always_comb begin
    any_req    = refresh_i | stop_i;
    sig_bad    = sig_en_i & (sig_a_i != sig_b_i);
    win_hit    = (cnt == win_tgt);
    skip_first = (first_len_i == '0);
  end

  // next-state and output decode
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    dec     = 1'b0;
    win_d   = 1'b0;
    tmo_d   = 1'b0;
    sys_d   = 1'b0;
    viol_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ld      = 1'b1;
          ld_val  = skip_first ? second_len_i : first_len_i;
          state_d = skip_first ? ST_SECOND : ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (any_req) begin
          viol_d  = 1'b1;
          sys_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (last) begin
          ld      = 1'b1;
          ld_val  = second_len_i;
          state_d = ST_SECOND;
        end else begin
          dec = 1'b1;
        end
      end
      ST_SECOND: begin
        win_d = win_hit & ~any_req;
        if (refresh_i) begin
          if (sig_bad) begin
            viol_d  = 1'b1;
            sys_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ld      = 1'b1;
            ld_val  = skip_first ? second_len_i : first_len_i;
            state_d = skip_first ? ST_SECOND : ST_FIRST;
          end
        end else if (stop_i) begin
          state_d = ST_IDLE;
        end else if (last) begin
          tmo_d = 1'b1;
          if (delay_en_i) begin
            ld      = 1'b1;
            ld_val  = delay_len_i;
            state_d = ST_DELAY;
          end else begin
            sys_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end else begin
          dec = 1'b1;
        end
      end
      ST_DELAY: begin
        if (last) begin
          sys_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= 1'b0;
      tmo_q   <= 1'b0;
      sys_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      tmo_q   <= tmo_d;
      sys_q   <= sys_d;
    end
  end

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_VIO] = viol_d;
    flag_set[FLAG_SYS] = sys_d;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    wdt_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[g]),
      .clr   (flag_clr_i[g]),
      .q     (flag_q[g])
    );
  end

  assign win_irq_o   = win_q;
  assign tmo_irq_o   = tmo_q;
  assign sys_err_o   = sys_q;
  assign viol_flag_o = flag_q[FLAG_VIO];
  assign sys_flag_o  = flag_q[FLAG_SYS];
endmodule

// File: rtl/wdt_windowed_chk.sv
module wdt_windowed_chk
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       refresh_i,
  input logic       stop_i,
  input logic [1:0] flag_clr_i,
  input logic       win_irq_o,
  input logic       tmo_irq_o,
  input logic       sys_err_o,
  input logic       viol_flag_o,
  input logic       sys_flag_o,
  input wdt_state_e state_q
);
  p_closed_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIRST && (refresh_i || stop_i)) |=> (sys_err_o && state_q == ST_IDLE));

  p_viol_with_sys_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag_o) |-> sys_err_o);

  p_sys_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_o |-> sys_flag_o);

  p_viol_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag_o && !flag_clr_i[0]) |=> viol_flag_o);

  p_sys_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_o |=> (!sys_err_o && !tmo_irq_o && !win_irq_o));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> (!win_irq_o && !tmo_irq_o && !sys_err_o));

  p_tmo_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq_o |=> !tmo_irq_o);

  p_delay_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_DELAY) |-> tmo_irq_o);
endmodule

bind wdt_windowed wdt_windowed_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .refresh_i   (refresh_i),
  .stop_i      (stop_i),
  .flag_clr_i  (flag_clr_i),
  .win_irq_o   (win_irq_o),
  .tmo_irq_o   (tmo_irq_o),
  .sys_err_o   (sys_err_o),
  .viol_flag_o (viol_flag_o),
  .sys_flag_o  (sys_flag_o),
  .state_q     (state_q)
);

// File: tb/tb_wdt_windowed.sv
module tb_wdt_windowed;
  localparam int CW = 16;
  localparam int SW = 32;
  localparam int EV_WIN = 0;
  localparam int EV_TMO = 1;
  localparam int EV_SYS = 2;
  localparam int RQ_REF = 0;
  localparam int RQ_STOP = 1;
  localparam int RQ_START = 2;
  localparam int RQ_BOTH = 3;
  localparam int RQ_REF_CLR = 4;

  logic clk, rst_n, start_i, refresh_i, stop_i, delay_en_i, sig_en_i;
  logic [CW-1:0] first_len_i, second_len_i, delay_len_i;
  logic [1:0] irq_sel_i, flag_clr_i;
  logic [SW-1:0] sig_a_i, sig_b_i;
  logic win_irq_o, tmo_irq_o, sys_err_o, viol_flag_o, sys_flag_o;

  int cyc = 0;
  int vectors = 0;
  int fails = 0;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } exp_t;
  exp_t sb[$];

  wdt_windowed #(.CW(CW), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .refresh_i(refresh_i), .stop_i(stop_i),
    .first_len_i(first_len_i), .second_len_i(second_len_i), .delay_len_i(delay_len_i),
    .delay_en_i(delay_en_i), .sig_en_i(sig_en_i), .irq_sel_i(irq_sel_i),
    .sig_a_i(sig_a_i), .sig_b_i(sig_b_i), .flag_clr_i(flag_clr_i),
    .win_irq_o(win_irq_o), .tmo_irq_o(tmo_irq_o), .sys_err_o(sys_err_o),
    .viol_flag_o(viol_flag_o), .sys_flag_o(sys_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    sb.push_back(e);
  endtask

  task automatic take(input int kind);
    exp_t e;
    vectors++;
    if (sb.size() == 0) begin
      fails++;
      $display("FAIL R8/R10 unexpected event: actual kind %0d at %0d, expected none", kind, cyc);
    end else begin
      e = sb.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        fails++;
        $display("FAIL %s: actual kind %0d at %0d, expected kind %0d at %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: outputs sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (win_irq_o) take(EV_WIN);
      if (tmo_irq_o) take(EV_TMO);
      if (sys_err_o) take(EV_SYS);
    end
  end

  task automatic expect_empty(input string req);
    vectors++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected events missing, first kind %0d at %0d, expected none left",
               req, sb.size(), sb[0].kind, sb[0].at);
      sb.delete();
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_start(output int base);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    base = cyc;
  endtask

  // request sampled in cycle n relative to base; returns on that cycle's falling edge
  task automatic req_at(input int base, input int n, input int what);
    wait_until(base + n - 1);
    case (what)
      RQ_REF:     refresh_i = 1'b1;
      RQ_STOP:    stop_i = 1'b1;
      RQ_START:   start_i = 1'b1;
      RQ_BOTH:    begin refresh_i = 1'b1; stop_i = 1'b1; end
      default:    begin refresh_i = 1'b1; flag_clr_i = 2'b11; end
    endcase
    @(negedge clk);
    refresh_i = 1'b0; stop_i = 1'b0; start_i = 1'b0; flag_clr_i = 2'b00;
  endtask

  task automatic clear_flags();
    flag_clr_i = 2'b11;
    @(negedge clk);
    flag_clr_i = 2'b00;
  endtask

  task automatic cfg(input int f, input int s, input int t, input bit den, input bit sen, input int sel);
    first_len_i = CW'(f); second_len_i = CW'(s); delay_len_i = CW'(t);
    delay_en_i = den; sig_en_i = sen; irq_sel_i = sel[1:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int b, r;
    rst_n = 1'b0; start_i = 1'b0; refresh_i = 1'b0; stop_i = 1'b0; flag_clr_i = 2'b00;
    sig_a_i = 32'hA5A5_0001; sig_b_i = 32'hA5A5_0001;
    cfg(4, 8, 5, 1'b0, 1'b0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_bit(win_irq_o | tmo_irq_o | sys_err_o, 1'b0, "R1 pulses after reset");
    check_bit(viol_flag_o, 1'b0, "R1 viol flag after reset");
    check_bit(sys_flag_o, 1'b0, "R1 sys flag after reset");

    // R2 R4 R5: plain timeout, interrupt at second window start
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0"); push(EV_TMO, b + 12, "R5 timeout");
    push(EV_SYS, b + 12, "R5 immediate sys");
    wait_until(b + 18); expect_empty("R2 R5 sequence");
    check_bit(sys_flag_o, 1'b1, "R11 sys flag set");
    check_bit(viol_flag_o, 1'b0, "R5 no violation");
    clear_flags();
    check_bit(sys_flag_o, 1'b0, "R11 sys flag cleared");

    // R6 delay, R4 half point, refresh ignored during delay
    cfg(4, 8, 5, 1'b1, 1'b0, 2);
    do_start(b);
    push(EV_WIN, b + 9, "R4 sel2"); push(EV_TMO, b + 12, "R6 timeout");
    push(EV_SYS, b + 17, "R6 delayed sys");
    req_at(b, 14, RQ_REF);
    wait_until(b + 22); expect_empty("R6 delay");
    check_bit(viol_flag_o, 1'b0, "R6 refresh in delay ignored");
    clear_flags();

    // R4 quarter point then R8 stop
    cfg(4, 8, 5, 1'b0, 1'b0, 1);
    do_start(b);
    push(EV_WIN, b + 7, "R4 sel1");
    req_at(b, 9, RQ_STOP);
    wait_until(b + 25); expect_empty("R8 stop");
    check_bit(viol_flag_o | sys_flag_o, 1'b0, "R8 stop leaves flags");

    // R4 three quarter point
    cfg(4, 8, 5, 1'b0, 1'b0, 3);
    do_start(b);
    push(EV_WIN, b + 11, "R4 sel3"); push(EV_TMO, b + 12, "R5 timeout");
    push(EV_SYS, b + 12, "R5 immediate sys");
    wait_until(b + 16); expect_empty("R4 sel3");
    clear_flags();

    // R3 refresh in first window
    cfg(4, 8, 5, 1'b0, 1'b0, 0);
    do_start(b);
    push(EV_SYS, b + 2, "R3 refresh in first window");
    req_at(b, 2, RQ_REF);
    wait_until(b + 16); expect_empty("R3 halt");
    check_bit(viol_flag_o, 1'b1, "R3 viol flag");
    clear_flags();

    // R3 stop in last first-window cycle
    do_start(b);
    push(EV_SYS, b + 4, "R3 stop at cycle F");
    req_at(b, 4, RQ_STOP);
    wait_until(b + 16); expect_empty("R3 boundary");
    check_bit(viol_flag_o, 1'b1, "R3 viol flag boundary");
    clear_flags();

    // R7 legal refresh restarts
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0");
    r = b + 6;
    push(EV_WIN, r + 5, "R7 restart win"); push(EV_TMO, r + 12, "R7 restart timeout");
    push(EV_SYS, r + 12, "R7 restart sys");
    req_at(b, 6, RQ_REF);
    wait_until(r + 16); expect_empty("R7 restart");
    check_bit(viol_flag_o, 1'b0, "R7 no violation");
    clear_flags();

    // R10 refresh in the expiry cycle wins
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0");
    r = b + 12;
    push(EV_WIN, r + 5, "R10 win after late refresh"); push(EV_TMO, r + 12, "R10 timeout later");
    push(EV_SYS, r + 12, "R10 sys later");
    req_at(b, 12, RQ_REF);
    wait_until(r + 16); expect_empty("R10 expiry collision");
    clear_flags();

    // R10 refresh and stop together act as refresh
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0");
    r = b + 7;
    push(EV_WIN, r + 5, "R10 both acts as refresh");
    req_at(b, 7, RQ_BOTH);
    req_at(r, 7, RQ_STOP);
    wait_until(r + 20); expect_empty("R10 both");
    check_bit(sys_flag_o, 1'b0, "R10 both no sys");

    // R2 first length 0
    cfg(0, 8, 5, 1'b0, 1'b0, 0);
    do_start(b);
    push(EV_WIN, b + 1, "R2 zero first window");
    r = b + 2;
    push(EV_WIN, r + 1, "R2 restart zero"); push(EV_TMO, r + 8, "R2 zero timeout");
    push(EV_SYS, r + 8, "R2 zero sys");
    req_at(b, 2, RQ_REF);
    wait_until(r + 12); expect_empty("R2 zero first");
    check_bit(viol_flag_o, 1'b0, "R2 early refresh legal");
    clear_flags();

    // R9 signature mismatch
    cfg(4, 8, 5, 1'b0, 1'b1, 0);
    sig_b_i = 32'hA5A5_0002;
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0");
    push(EV_SYS, b + 7, "R9 signature mismatch");
    req_at(b, 7, RQ_REF);
    wait_until(b + 20); expect_empty("R9 mismatch");
    check_bit(viol_flag_o, 1'b1, "R9 viol flag");
    clear_flags();

    // R9 comparison disabled
    sig_en_i = 1'b0;
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0");
    r = b + 7;
    push(EV_WIN, r + 5, "R9 disabled refresh accepted");
    req_at(b, 7, RQ_REF);
    req_at(r, 7, RQ_STOP);
    wait_until(r + 20); expect_empty("R9 disabled");
    check_bit(viol_flag_o, 1'b0, "R9 disabled no violation");
    sig_b_i = sig_a_i;

    // R12 start while running ignored
    do_start(b);
    push(EV_WIN, b + 5, "R12 win unchanged"); push(EV_TMO, b + 12, "R12 timeout unchanged");
    push(EV_SYS, b + 12, "R12 sys unchanged");
    req_at(b, 3, RQ_START);
    wait_until(b + 16); expect_empty("R12 start ignored");
    clear_flags();

    // R11 set wins over clear
    do_start(b);
    push(EV_SYS, b + 2, "R11 violation with clear");
    req_at(b, 2, RQ_REF_CLR);
    check_bit(viol_flag_o, 1'b1, "R11 viol set wins");
    check_bit(sys_flag_o, 1'b1, "R11 sys set wins");
    wait_until(b + 8); expect_empty("R11 collision");
    clear_flags();
    check_bit(viol_flag_o, 1'b0, "R11 viol cleared");

    // R1 reset during the second window
    do_start(b);
    push(EV_WIN, b + 5, "R4 sel0");
    wait_until(b + 7);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_until(b + 30); expect_empty("R1 reset mid window");
    check_bit(viol_flag_o | sys_flag_o, 1'b0, "R1 flags after mid reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule